// File: doc/BRIEF.md
# Averaging ADC Sequencer with Register Front End

This block sits between a 32-bit single-cycle register bus and a 12-bit multi-channel sampling converter. Software picks a channel, an output format, a first-result delay, a sample pace and a sample count, then writes a start command. The block waits out the delay and requests samples one at a time at the programmed pace. It sums the returned codes and divides the sum by a power of two with a shift. It then stores the formatted average, raises a finished flag and posts an interrupt.

The converter side has a channel select, a one-cycle request pulse and a 12-bit result with a valid strobe. The block does not constrain how long the converter takes to answer. The pacing timer starts from the clock edge that takes each result. The clock of the block is the converter clock, so all delays and intervals are counted in that clock.

Top module: `adc_avg_ctrl`

## Requirements
- R1: After reset, word 0x00 reads 0x0000_0002, word 0x04 reads 0x0000_0720, words 0x08, 0x0C, 0x10 and 0x14 read zero, word 0x20 reads 0x8000_0008 whatever is written there, any other word reads zero, and `irq` is low.
- R2: Bits with no function read as zero and writes to them are dropped. Writing all ones to word 0x04 reads back 0x0000_077F. Writing 0xFFFF_FFFE to word 0x10 reads back zero.
- R3: Writing 1 to bit 0 of word 0x00 while idle starts a sequence. That bit always reads 0. A start written while a sequence runs is ignored and neither restarts nor lengthens the run.
- R4: When bits [2:1] of word 0x00 are written as 2, a running sequence stops at once with no further requests and status bit 2 reads 0. A start is ignored while the field holds 2. Writing any other field value lets starts run again.
- R5: Configuration bit 9 picks the first-request delay. With 0, `cvStart` goes high on the 40th clock edge after the edge that accepts the start. With 1 it goes high on the 20th such edge.
- R6: Configuration bit 8 picks the pace. After the edge that takes a sample with `cvValid`, the next request goes high on the SLOW_GAP-th edge (bit 8 = 0, default 80) or the FAST_GAP-th edge (bit 8 = 1, default 4).
- R7: Configuration bits [6:4] hold a code n, and one start issues exactly 2^n requests. Code 7 behaves as code 6 (64 requests).
- R8: Word 0x0C bits [11:0] take floor(sum of the samples / 2^n) on the edge that takes the last sample, and bits [31:12] read zero. The data word changes at no other time.
- R9: Configuration bit 10 selects the format. 1 stores the average as is (offset binary). 0 stores it with bit 11 inverted (two's complement).
- R10: Status word 0x08 bit 2 reads 0 from the accepting edge until the sequence ends, and 1 after it ends.
- R11: `cvChannel` follows configuration bits [3:0]. If those bits hold 10 to 15 when a start arrives, the sequence ends at once: no request is made, the data word is unchanged, and the finished flag and interrupt status are set.
- R12: Interrupt-status word 0x14 bit 0 is set at the end of every sequence. Writing 1 clears it, and writing 0 leaves it. `irq` is high exactly when that bit and bit 0 of word 0x10 are both 1.
- R13: `cvStart` is a single-cycle pulse, and the channel it presents is always 0 to 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 6 | Byte address; bits [5:2] select the word |
| busWe | input | 1 | Write enable for one cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the addressed word, combinational |
| cvChannel | output | 4 | Channel select to the converter |
| cvStart | output | 1 | One-cycle sample request |
| cvSample | input | 12 | Raw sample from the converter |
| cvValid | input | 1 | Marks `cvSample` as valid for one cycle |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after off-by-one errors in the delay and pace timers, because a timer loaded with the full count instead of count minus one moves every request by a clock. It also checks the sample count at both ends, where code 0 must give one sample and code 7 must not give 128. A wrong sum width would show when long runs of high codes wrap, and a wrongly placed shift would show as a rounding error in the average. A design that lets a second start restart the sequence would issue extra requests. One that keeps running under soft reset, or that drives the converter for a reserved channel, would show a request count that is not zero. Write-zero on the interrupt status and the set-versus-clear order are checked at `irq`.

// File: rtl/adc_avg_pkg.sv
package adc_avg_pkg;

  localparam int WORD_W = 4;
  localparam int ADDR_W = WORD_W + 2;

  localparam logic [WORD_W-1:0] WORD_CTRL = 4'h0;
  localparam logic [WORD_W-1:0] WORD_CFG  = 4'h1;
  localparam logic [WORD_W-1:0] WORD_STAT = 4'h2;
  localparam logic [WORD_W-1:0] WORD_DATA = 4'h3;
  localparam logic [WORD_W-1:0] WORD_IEN  = 4'h4;
  localparam logic [WORD_W-1:0] WORD_IST  = 4'h5;
  localparam logic [WORD_W-1:0] WORD_VER  = 4'h8;

  localparam logic [31:0] VERSION_WORD = 32'h8000_0008;
  localparam logic [1:0]  SOFT_HOLD_CODE = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_REQ,
    ST_CAPT
  } seqState_t;

  typedef struct packed {
    logic clear;
    logic accumulate;
    logic commit;
  } dpStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_avg_datapath.sv
module adc_avg_datapath
  import adc_avg_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int MAX_CODE = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [SAMPLE_W-1:0] cvSample,
  input  logic [2:0]          shiftCode,
  input  logic                fmtOffset,
  output logic [SAMPLE_W-1:0] dataValue
);

  localparam int ACC_W = SAMPLE_W + MAX_CODE + 1;
  localparam int NUM_SHIFT = MAX_CODE + 1;

  logic [ACC_W-1:0]    acc;
  logic [ACC_W-1:0]    sumNext;
  logic [SAMPLE_W-1:0] shifted [NUM_SHIFT];
  logic [SAMPLE_W-1:0] avg;
  logic [SAMPLE_W-1:0] formatted;

  assign sumNext = acc + ACC_W'(cvSample);

  // one tap per legal shift amount; the divide is a select
  for (genvar g = 0; g < NUM_SHIFT; g++) begin : g_shift
    assign shifted[g] = sumNext[g +: SAMPLE_W];
  end

  always_comb begin
    avg = shifted[0];
    for (int i = 1; i < NUM_SHIFT; i++) begin
      if (shiftCode == 3'(i)) avg = shifted[i];
    end
  end

  // two's complement form: flip the top bit of the offset code
  assign formatted = fmtOffset ? avg : {~avg[SAMPLE_W-1], avg[SAMPLE_W-2:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc       <= '0;
      dataValue <= '0;
    end else begin
      if (strobe.clear)           acc <= '0;
      else if (strobe.accumulate) acc <= sumNext;
      if (strobe.commit) dataValue <= formatted;
    end
  end

endmodule

// File: rtl/adc_avg_control.sv
module adc_avg_control
  import adc_avg_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int MAX_CODE  = 6,
  parameter int NUM_CH    = 10,
  parameter int LAT_LONG  = 40,
  parameter int LAT_SHORT = 20,
  parameter int SLOW_GAP  = 80,
  parameter int FAST_GAP  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWe,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  input  logic [SAMPLE_W-1:0] dataValue,
  output logic [3:0]          cvChannel,
  output logic                cvStart,
  input  logic                cvValid,
  output logic                irq,
  output dpStrobe_t           strobe,
  output logic [2:0]          shiftCode,
  output logic                fmtOffset,
  output logic                seqEnd,
  output logic                softHold,
  output logic                doneFlag,
  output logic                intStatus,
  output logic                intEnable
);

  localparam int TIMER_MAX = maxOf(maxOf(LAT_LONG, LAT_SHORT), maxOf(SLOW_GAP, FAST_GAP));
  localparam int TIMER_W   = $clog2(TIMER_MAX + 1);
  localparam int CNT_W     = MAX_CODE + 1;
  localparam logic [TIMER_W-1:0] LONG_LOAD  = TIMER_W'(LAT_LONG - 1);
  localparam logic [TIMER_W-1:0] SHORT_LOAD = TIMER_W'(LAT_SHORT - 1);
  localparam logic [TIMER_W-1:0] SLOW_LOAD  = TIMER_W'(SLOW_GAP - 1);
  localparam logic [TIMER_W-1:0] FAST_LOAD  = TIMER_W'(FAST_GAP - 1);
  localparam logic [2:0] CODE_CAP = 3'(MAX_CODE);
  localparam logic [3:0] CH_LIMIT = 4'(NUM_CH);

  // register fields
  logic [1:0] softField;
  logic       cfgFormat;
  logic       cfgLatSel;
  logic       cfgRate;
  logic [2:0] cfgCode;
  logic [3:0] cfgChan;

  seqState_t        state;
  logic [TIMER_W-1:0] timer;
  logic [CNT_W-1:0] sampCount;

  logic [WORD_W-1:0] wordSel;
  logic wrCtrl, wrCfg, wrIen, wrIst;
  logic startReq, abortReq, chanOk, lastSample, takeSample;
  logic [2:0] effCode;

  assign wordSel = busAddr[ADDR_W-1:2];
  assign wrCtrl  = busWe && (wordSel == WORD_CTRL);
  assign wrCfg   = busWe && (wordSel == WORD_CFG);
  assign wrIen   = busWe && (wordSel == WORD_IEN);
  assign wrIst   = busWe && (wordSel == WORD_IST);

  assign effCode    = (cfgCode > CODE_CAP) ? CODE_CAP : cfgCode;
  assign chanOk     = cfgChan < CH_LIMIT;
  assign lastSample = sampCount == CNT_W'((32'd1 << effCode) - 32'd1);
  assign abortReq   = wrCtrl && (busWdata[2:1] == SOFT_HOLD_CODE);
  assign startReq   = wrCtrl && busWdata[0] && (busWdata[2:1] != SOFT_HOLD_CODE)
                      && (state == ST_IDLE);
  assign takeSample = (state == ST_CAPT) && cvValid && !abortReq;

  assign strobe.clear      = (startReq && chanOk) || abortReq;
  assign strobe.accumulate = takeSample;
  assign strobe.commit     = takeSample && lastSample;
  assign seqEnd            = (takeSample && lastSample) || (startReq && !chanOk);

  assign shiftCode = effCode;
  assign fmtOffset = cfgFormat;
  assign softHold  = softField == SOFT_HOLD_CODE;
  assign cvStart   = state == ST_REQ;
  assign cvChannel = cfgChan;
  assign irq       = intStatus && intEnable;

  // register file writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      softField <= 2'd1;
      cfgFormat <= 1'b1;
      cfgLatSel <= 1'b1;
      cfgRate   <= 1'b1;
      cfgCode   <= 3'd2;
      cfgChan   <= 4'd0;
      intEnable <= 1'b0;
      intStatus <= 1'b0;
    end else begin
      if (wrCtrl) softField <= busWdata[2:1];
      if (wrCfg) begin
        cfgFormat <= busWdata[10];
        cfgLatSel <= busWdata[9];
        cfgRate   <= busWdata[8];
        cfgCode   <= busWdata[6:4];
        cfgChan   <= busWdata[3:0];
      end
      if (wrIen) intEnable <= busWdata[0];
      // a finishing sequence wins over a clear in the same cycle
      if (seqEnd)                   intStatus <= 1'b1;
      else if (wrIst && busWdata[0]) intStatus <= 1'b0;
    end
  end

  // sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      timer     <= '0;
      sampCount <= '0;
      doneFlag  <= 1'b0;
    end else if (abortReq) begin
      state    <= ST_IDLE;
      doneFlag <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startReq) begin
            if (chanOk) begin
              state     <= ST_WAIT;
              timer     <= cfgLatSel ? SHORT_LOAD : LONG_LOAD;
              sampCount <= '0;
              doneFlag  <= 1'b0;
            end else begin
              doneFlag <= 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (timer == '0) state <= ST_REQ;
          else             timer <= timer - 1'b1;
        end
        ST_REQ: state <= ST_CAPT;
        ST_CAPT: begin
          if (cvValid) begin
            if (lastSample) begin
              state    <= ST_IDLE;
              doneFlag <= 1'b1;
            end else begin
              state     <= ST_WAIT;
              timer     <= cfgRate ? FAST_LOAD : SLOW_LOAD;
              sampCount <= sampCount + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // read mux
  always_comb begin
    busRdata = '0;
    unique case (wordSel)
      WORD_CTRL: busRdata = {29'b0, softField, 1'b0};
      WORD_CFG:  busRdata = {21'b0, cfgFormat, cfgLatSel, cfgRate, 1'b0, cfgCode, cfgChan};
      WORD_STAT: busRdata = {29'b0, doneFlag, 2'b0};
      WORD_DATA: busRdata = 32'(dataValue);
      WORD_IEN:  busRdata = {31'b0, intEnable};
      WORD_IST:  busRdata = {31'b0, intStatus};
      WORD_VER:  busRdata = VERSION_WORD;
      default:   busRdata = '0;
    endcase
  end

endmodule

// File: rtl/adc_avg_ctrl.sv
module adc_avg_ctrl
  import adc_avg_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int MAX_CODE  = 6,
  parameter int NUM_CH    = 10,
  parameter int LAT_LONG  = 40,
  parameter int LAT_SHORT = 20,
  parameter int SLOW_GAP  = 80,
  parameter int FAST_GAP  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWe,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  output logic [3:0]          cvChannel,
  output logic                cvStart,
  input  logic [SAMPLE_W-1:0] cvSample,
  input  logic                cvValid,
  output logic                irq
);

  dpStrobe_t           strobe;
  logic [SAMPLE_W-1:0] dataValue;
  logic [2:0]          shiftCode;
  logic                fmtOffset;
  logic                seqEnd;
  logic                softHold;
  logic                doneFlag;
  logic                intStatus;
  logic                intEnable;

  adc_avg_control #(
    .SAMPLE_W (SAMPLE_W),
    .MAX_CODE (MAX_CODE),
    .NUM_CH   (NUM_CH),
    .LAT_LONG (LAT_LONG),
    .LAT_SHORT(LAT_SHORT),
    .SLOW_GAP (SLOW_GAP),
    .FAST_GAP (FAST_GAP)
  ) u_control (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWe    (busWe),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .dataValue(dataValue),
    .cvChannel(cvChannel),
    .cvStart  (cvStart),
    .cvValid  (cvValid),
    .irq      (irq),
    .strobe   (strobe),
    .shiftCode(shiftCode),
    .fmtOffset(fmtOffset),
    .seqEnd   (seqEnd),
    .softHold (softHold),
    .doneFlag (doneFlag),
    .intStatus(intStatus),
    .intEnable(intEnable)
  );

  adc_avg_datapath #(
    .SAMPLE_W(SAMPLE_W),
    .MAX_CODE(MAX_CODE)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cvSample (cvSample),
    .shiftCode(shiftCode),
    .fmtOffset(fmtOffset),
    .dataValue(dataValue)
  );

endmodule

// File: rtl/adc_avg_checker.sv
module adc_avg_checker
  import adc_avg_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busWe,
  input logic [31:0]         busWdata,
  input logic                cvStart,
  input logic [3:0]          cvChannel,
  input dpStrobe_t           strobe,
  input logic [SAMPLE_W-1:0] dataValue,
  input logic                seqEnd,
  input logic                softHold,
  input logic                doneFlag,
  input logic                intStatus
);

  assert_req_pulse_R13: assert property (@(posedge clk) disable iff (!rstN)
    cvStart |=> !cvStart);

  assert_req_channel_R13: assert property (@(posedge clk) disable iff (!rstN)
    cvStart |-> (cvChannel < 4'd10));

  assert_hold_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    softHold |-> !cvStart);

  assert_flag_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    cvStart |-> !doneFlag);

  assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(dataValue));

  assert_w1c_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr[ADDR_W-1:2] == WORD_IST && busWdata[0] && !seqEnd) |=> !intStatus);

  assert_end_sets_R12: assert property (@(posedge clk) disable iff (!rstN)
    seqEnd |=> intStatus);

endmodule

bind adc_avg_ctrl adc_avg_checker #(.SAMPLE_W(SAMPLE_W)) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWe    (busWe),
  .busWdata (busWdata),
  .cvStart  (cvStart),
  .cvChannel(cvChannel),
  .strobe   (strobe),
  .dataValue(dataValue),
  .seqEnd   (seqEnd),
  .softHold (softHold),
  .doneFlag (doneFlag),
  .intStatus(intStatus)
);

// File: tb/adc_avg_ctrl_bench.sv
module adc_avg_ctrl_bench;

  localparam int LAT_LONG  = 40;
  localparam int LAT_SHORT = 20;
  localparam int SLOW_GAP  = 80;
  localparam int FAST_GAP  = 4;

  typedef struct packed {
    logic [31:0] cfg;
    logic [11:0] base;
    logic [11:0] step;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{cfg: 32'h0000_0710, base: 12'd100,  step: 12'd7},
    '{cfg: 32'h0000_0403, base: 12'hABC,  step: 12'd0},
    '{cfg: 32'h0000_0323, base: 12'h7F0,  step: 12'd5},
    '{cfg: 32'h0000_0761, base: 12'hF00,  step: 12'd3},
    '{cfg: 32'h0000_0579, base: 12'd1,    step: 12'd64},
    '{cfg: 32'h0000_0250, base: 12'h800,  step: 12'd1},
    '{cfg: 32'h0000_0634, base: 12'h123,  step: 12'h111}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0]  cvChannel;
  logic        cvStart;
  logic [11:0] cvSample;
  logic        cvValid;
  logic        irq;

  always #5 clk = ~clk;

  adc_avg_ctrl u_adc_avg_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRdata(busRdata), .cvChannel(cvChannel), .cvStart(cvStart),
    .cvSample(cvSample), .cvValid(cvValid), .irq(irq)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // converter model and request monitor, both sampling at the falling edge
  logic markReq = 1'b0;
  int   modelBase = 0;
  int   modelStep = 0;
  logic [3:0] expChan = '0;
  int   modelIdx = 0;
  logic pend = 1'b0;
  logic vld = 1'b0;
  logic [11:0] smp = '0;
  assign cvValid  = vld;
  assign cvSample = smp;

  always @(negedge clk) begin
    pend <= cvStart;
    vld  <= pend;
    if (pend) begin
      smp <= 12'(modelBase + modelStep * modelIdx);
      modelIdx <= modelIdx + 1;
    end
    if (markReq) modelIdx <= 0;
  end

  int cyc = 0;
  int mark = 0;
  int firstLat = -1;
  int gapMin = 0;
  int gapMax = 0;
  int lastReq = 0;
  int reqCount = 0;
  bit chanBad = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (markReq) begin
      mark = cyc; reqCount = 0; firstLat = -1;
      gapMin = 1000000; gapMax = 0; chanBad = 0;
    end
    if (cvStart) begin
      if (reqCount == 0) firstLat = cyc - mark;
      else begin
        if (cyc - lastReq < gapMin) gapMin = cyc - lastReq;
        if (cyc - lastReq > gapMax) gapMax = cyc - lastReq;
      end
      lastReq = cyc;
      reqCount = reqCount + 1;
      if (cvChannel != expChan) chanBad = 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input int addr, input int data, input bit marked);
    @(posedge clk); #1;
    busAddr = 6'(addr); busWdata = 32'(data); busWe = 1'b1; markReq = marked;
    @(posedge clk); #1;
    busWe = 1'b0; markReq = 1'b0;
  endtask

  task automatic readReg(input int addr, output int data);
    @(posedge clk); #1;
    busAddr = 6'(addr); busWe = 1'b0;
    @(negedge clk);
    data = int'(busRdata);
  endtask

  task automatic waitDone(input string req);
    int st;
    int n;
    st = 0;
    for (n = 0; n < 8000; n++) begin
      readReg(8, st);
      if (st[2]) break;
    end
    check(req, st & 4, 4);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  function automatic int expAvg(input int cfg, input int base, input int step);
    int code, eff, sum, avg;
    code = (cfg >> 4) & 7;
    eff = (code == 7) ? 6 : code;
    sum = 0;
    for (int i = 0; i < (1 << eff); i++) sum += (base + step * i) & 4095;
    avg = (sum >> eff) & 4095;
    if (((cfg >> 10) & 1) == 0) avg = avg ^ 2048;
    return avg;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    int code;
    int nreq;
    int lastData;
    int rc;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    readReg(8'h00, v); check("R1 ctrl", v, 32'h2);
    readReg(8'h04, v); check("R1 cfg", v, 32'h720);
    readReg(8'h08, v); check("R1 status", v, 0);
    readReg(8'h0C, v); check("R1 data", v, 0);
    readReg(8'h10, v); check("R1 int enable", v, 0);
    readReg(8'h14, v); check("R1 int status", v, 0);
    readReg(8'h20, v); check("R1 version", v, 32'h8000_0008);
    readReg(8'h18, v); check("R1 unmapped", v, 0);
    check("R1 irq", int'(irq), 0);
    writeReg(8'h20, 0, 0);
    readReg(8'h20, v); check("R1 version after write", v, 32'h8000_0008);

    // R2: reserved bits
    writeReg(8'h04, 32'hFFFF_FFFF, 0);
    readReg(8'h04, v); check("R2 cfg reserved", v, 32'h77F);
    writeReg(8'h10, 32'hFFFF_FFFE, 0);
    readReg(8'h10, v); check("R2 int enable reserved", v, 0);
    writeReg(8'h00, 32'hFFFF_FFF8, 0);
    readReg(8'h00, v); check("R2 ctrl reserved", v, 0);
    writeReg(8'h00, 32'h2, 0);

    // vector table: R5 R6 R7 R8 R9 R10 R12 R13
    for (int k = 0; k < NVEC; k++) begin
      writeReg(8'h04, int'(VECS[k].cfg), 0);
      modelBase = int'(VECS[k].base);
      modelStep = int'(VECS[k].step);
      expChan = VECS[k].cfg[3:0];
      code = int'(VECS[k].cfg[6:4]);
      nreq = (code == 7) ? 64 : (1 << code);
      writeReg(8'h00, 32'h3, 1);
      readReg(8'h08, v); check("R10 busy flag", v & 4, 0);
      readReg(8'h00, v); check("R3 start reads zero", v, 32'h2);
      waitDone("R10 done flag");
      // sampled at the falling edge after the edge that raised the request
      check("R5 first latency", firstLat, (VECS[k].cfg[9] ? LAT_SHORT : LAT_LONG) + 1);
      check("R7 request count", reqCount, nreq);
      if (nreq > 1) begin
        check("R6 gap min", gapMin, (VECS[k].cfg[8] ? FAST_GAP : SLOW_GAP) + 2);
        check("R6 gap max", gapMax, (VECS[k].cfg[8] ? FAST_GAP : SLOW_GAP) + 2);
      end
      check("R13 channel", int'(chanBad), 0);
      readReg(8'h0C, v);
      check("R8 R9 average", v, expAvg(int'(VECS[k].cfg), modelBase, modelStep));
      readReg(8'h14, v); check("R12 int status set", v, 1);
      writeReg(8'h14, 1, 0);
      readReg(8'h14, v); check("R12 int cleared", v, 0);
    end

    // R3: second start while running is ignored
    writeReg(8'h04, 32'h762, 0);
    modelBase = 10; modelStep = 1; expChan = 4'd2;
    writeReg(8'h00, 32'h3, 1);
    idle(60);
    writeReg(8'h00, 32'h3, 0);
    waitDone("R3 done");
    check("R3 ignored start count", reqCount, 64);
    check("R3 ignored start latency", firstLat, LAT_SHORT + 1);
    readReg(8'h0C, v); check("R3 data", v, expAvg(32'h762, 10, 1));
    lastData = v;

    // R12: interrupt gating and write-one-to-clear
    check("R12 irq masked", int'(irq), 0);
    writeReg(8'h14, 0, 0);
    readReg(8'h14, v); check("R12 write zero keeps", v, 1);
    writeReg(8'h10, 1, 0);
    @(negedge clk); check("R12 irq raised", int'(irq), 1);
    writeReg(8'h14, 1, 0);
    @(negedge clk); check("R12 irq cleared", int'(irq), 0);

    // R11: reserved channel finishes at once
    writeReg(8'h04, 32'h71A, 0);
    expChan = 4'hA;
    writeReg(8'h00, 32'h3, 1);
    readReg(8'h08, v); check("R11 immediate done", v & 4, 4);
    idle(60);
    check("R11 no request", reqCount, 0);
    readReg(8'h0C, v); check("R11 data unchanged", v, lastData);
    @(negedge clk); check("R11 R12 irq", int'(irq), 1);
    writeReg(8'h14, 1, 0);
    writeReg(8'h10, 0, 0);

    // R4: soft reset aborts, blocks starts, then releases
    writeReg(8'h04, 32'h460, 0);
    expChan = 4'd0; modelBase = 5; modelStep = 2;
    writeReg(8'h00, 32'h3, 1);
    idle(150);
    writeReg(8'h00, 32'h4, 0);
    rc = reqCount;
    idle(300);
    check("R4 no requests after abort", reqCount, rc);
    readReg(8'h08, v); check("R4 flag cleared", v & 4, 0);
    readReg(8'h00, v); check("R4 field reads back", v, 32'h4);
    writeReg(8'h00, 32'h5, 1);
    idle(100);
    check("R4 start blocked", reqCount, 0);
    readReg(8'h08, v); check("R4 still not done", v & 4, 0);
    writeReg(8'h00, 32'h3, 1);
    waitDone("R4 release done");
    check("R4 release count", reqCount, 64);
    readReg(8'h0C, v); check("R4 release data", v, expAvg(32'h460, 5, 2));

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule